// File: doc/BRIEF.md
# Bus Endianness Swap Controller

This block sits on the data path between a host CPU port, a 32-bit PCI port acting as either master or target, and a 64-bit internal bus. Each transfer carries a source interface code, a direction flag, and a flag that says whether the far end is an internal register or an external memory or device. From these and two programmable configuration words, the block decides whether to reverse the bytes inside each 32-bit word and whether to exchange the two 32-bit words of the 64-bit doubleword. It applies the same permutation to the data and to the per-byte enables.

A control bit does not mean the same thing on every path. On the CPU path, a clear bit swaps bytes for internal-register traffic. On the PCI path, a clear bit swaps bytes for external traffic. The block also reports which half of the 64-bit bus holds an addressed 32-bit word. It derives this from address bit 2 and the endian mode in force for that transfer.

The swap decision and the data mux are combinational. They feed a single output register with a valid/ready handshake, and backpressure from the output passes through to the input. Software reads and writes the two configuration words through a small register port.

Top module: `endian_swap_ctrl`

## Requirements
- R1: Two 32-bit configuration words, the CPU word (cfg_sel_i=0) and the PCI command word (cfg_sel_i=1), reset to 0. A write with cfg_we_i stores all 32 bits into the selected word from the next cycle on. cfg_rdata_o always shows the selected word.
- R2: For CPU transfers (in_src_i=0), bit 12 of the CPU word set to 1 means no byte swap. Bit 12 cleared to 0 means bytes are swapped only when in_internal_i=1.
- R3: PCI master transfers (in_src_i=1) are governed by bit 0 of the PCI command word. PCI target transfers (in_src_i=2) are governed by bit 16 of the same word. A governing bit of 1 means no byte swap. A governing bit of 0 means bytes are swapped only when in_internal_i=0.
- R4: The two words are exchanged only for PCI transfers (in_src_i=1 or 2) and only when three conditions all hold: bits 12:10 of the PCI command word are all 1, pci_wide_i=0, and in_internal_i=0. CPU transfers never exchange words.
- R5: With pci_wide_i=1 (64-bit PCI), word exchange never happens, whatever the command word holds.
- R6: A byte swap maps byte k of each 32-bit half to byte 3-k of the same half, for both data and byte enables.
- R7: A word exchange swaps data bits 31:0 with 63:32 and byte enables 3:0 with 7:4. It is applied after any byte swap.
- R8: out_lane_hi_o equals address bit 2 in little-endian mode and its inverse in big-endian mode. For CPU transfers the mode is little-endian when CPU bit 12 is 1. For PCI transfers it is little-endian when the governing role bit (R3) is 1.
- R9: Source code 3 is reserved. It applies no swap of either kind and treats the transfer as little-endian.
- R10: A transfer accepted when in_valid_i and in_ready_o are both high appears on out_valid_o after the next clock edge. in_ready_o is high when the output register is empty or out_ready_i is high. A stalled output holds its values.
- R11: The direction flag passes through unchanged, and neither swap decision depends on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Configuration word select: 0 CPU, 1 PCI command |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Selected configuration word |
| pci_wide_i | input | 1 | PCI port is 64 bits wide |
| in_valid_i | input | 1 | Input transfer valid |
| in_ready_o | output | 1 | Input transfer accepted |
| in_src_i | input | 2 | Source: 0 CPU, 1 PCI master, 2 PCI target, 3 reserved |
| in_write_i | input | 1 | Direction flag |
| in_internal_i | input | 1 | Far end is an internal register |
| in_addr2_i | input | 1 | Address bit 2 |
| in_data_i | input | 64 | Transfer data |
| in_be_i | input | 8 | Byte enables |
| out_valid_o | output | 1 | Output transfer valid |
| out_ready_i | input | 1 | Output consumer ready |
| out_write_o | output | 1 | Direction flag, passed through |
| out_data_o | output | 64 | Data after swapping |
| out_be_o | output | 8 | Byte enables after swapping |
| out_lane_hi_o | output | 1 | Addressed word sits in bits 63:32 |
| out_bswap_o | output | 1 | Byte swap was applied |
| out_wswap_o | output | 1 | Word exchange was applied |

## Verification
On every cycle, the assertions check the following:
- Configuration writes land in the selected word.
- An accepted transfer always shows up as valid one edge later.
- A stalled output holds its values.
- Swapping never changes the number of enabled bytes.
- Word exchange never occurs for CPU or reserved sources, for internal-register traffic, or on a wide PCI port.

The swap decisions themselves only show up through the bench's scenarios. These are the opposite polarity between the CPU and PCI paths, the independent master and target bits, and the lane select under each endian mode. The bench walks a range of configuration words and compares each output against a model built from the requirements.

// File: rtl/endian_swap_pkg.sv
package endian_swap_pkg;

  typedef enum logic [1:0] {
    SRC_CPU     = 2'd0,
    SRC_PCI_MST = 2'd1,
    SRC_PCI_TGT = 2'd2,
    SRC_RSVD    = 2'd3
  } src_e;

  localparam int CFG_W       = 32;
  localparam int CPU_LE_BIT  = 12;
  localparam int PCI_MST_BIT = 0;
  localparam int PCI_TGT_BIT = 16;
  localparam int WSW_LSB     = 10;
  localparam int WSW_W       = 3;

  typedef struct packed {
    logic bswap;
    logic wswap;
    logic lane_hi;
  } swap_ctl_t;

endpackage

// File: rtl/swap_cfg_regs.sv
module swap_cfg_regs
  import endian_swap_pkg::*;
#(
  parameter int REG_W = CFG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [REG_W-1:0] cpu_cfg_o,
  output logic [REG_W-1:0] pci_cmd_o
);

  logic [REG_W-1:0] cpu_q, pci_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_q <= '0;
      pci_q <= '0;
    end else if (we_i) begin
      if (sel_i) pci_q <= wdata_i;
      else       cpu_q <= wdata_i;
    end
  end

  assign rdata_o   = sel_i ? pci_q : cpu_q;
  assign cpu_cfg_o = cpu_q;
  assign pci_cmd_o = pci_q;

  // R1
  cfg_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ($past(sel_i) ? pci_cmd_o : cpu_cfg_o) == $past(wdata_i));

endmodule

// File: rtl/swap_decide.sv
module swap_decide
  import endian_swap_pkg::*;
#(
  parameter int REG_W = CFG_W
) (
  input  logic [1:0]       src_i,
  input  logic             internal_i,
  input  logic             addr2_i,
  input  logic             pci_wide_i,
  input  logic [REG_W-1:0] cpu_cfg_i,
  input  logic [REG_W-1:0] pci_cmd_i,
  output swap_ctl_t        ctl_o
);

  src_e src;
  logic cpu_le, role_bit, wsw_en, little;

  assign src      = src_e'(src_i);
  assign cpu_le   = cpu_cfg_i[CPU_LE_BIT];
  assign role_bit = (src == SRC_PCI_TGT) ? pci_cmd_i[PCI_TGT_BIT] : pci_cmd_i[PCI_MST_BIT];
  // word exchange needs the whole field set and a 32-bit PCI port
  assign wsw_en   = (&pci_cmd_i[WSW_LSB +: WSW_W]) && !pci_wide_i;

  always_comb begin
    ctl_o  = '0;
    little = 1'b1;
    unique case (src)
      SRC_CPU: begin
        little      = cpu_le;
        ctl_o.bswap = !cpu_le && internal_i;
      end
      SRC_PCI_MST, SRC_PCI_TGT: begin
        little      = role_bit;
        ctl_o.bswap = !role_bit && !internal_i;
        ctl_o.wswap = wsw_en && !internal_i;
      end
      default: little = 1'b1;
    endcase
    ctl_o.lane_hi = addr2_i ^ !little;
  end

endmodule

// File: rtl/swap_lanes.sv
module swap_lanes #(
  parameter  int DATA_W = 64,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic              bswap_i,
  input  logic              wswap_i,
  output logic [DATA_W-1:0] data_o,
  output logic [BE_W-1:0]   be_o
);

  localparam int WORD_W = 32;
  localparam int BPW    = WORD_W / 8;
  localparam int NWORD  = DATA_W / WORD_W;

  logic [DATA_W-1:0] bs_data;
  logic [BE_W-1:0]   bs_be;

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    for (genvar b = 0; b < BPW; b++) begin : g_byte
      localparam int DST = w*BPW + b;
      localparam int SRC = w*BPW + (BPW-1-b);
      assign bs_data[DST*8 +: 8] = bswap_i ? data_i[SRC*8 +: 8] : data_i[DST*8 +: 8];
      assign bs_be[DST]          = bswap_i ? be_i[SRC]          : be_i[DST];
    end
    // pair partner within the doubleword
    localparam int PW = w ^ 1;
    assign data_o[w*WORD_W +: WORD_W] = wswap_i ? bs_data[PW*WORD_W +: WORD_W]
                                                : bs_data[w*WORD_W +: WORD_W];
    assign be_o[w*BPW +: BPW]         = wswap_i ? bs_be[PW*BPW +: BPW]
                                                : bs_be[w*BPW +: BPW];
  end

endmodule

// File: rtl/endian_swap_ctrl.sv
module endian_swap_ctrl
  import endian_swap_pkg::*;
#(
  parameter  int DATA_W = 64,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [CFG_W-1:0]  cfg_rdata_o,
  input  logic              pci_wide_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [1:0]        in_src_i,
  input  logic              in_write_i,
  input  logic              in_internal_i,
  input  logic              in_addr2_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [BE_W-1:0]   in_be_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_write_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [BE_W-1:0]   out_be_o,
  output logic              out_lane_hi_o,
  output logic              out_bswap_o,
  output logic              out_wswap_o
);

  logic [CFG_W-1:0]  cpu_cfg, pci_cmd;
  swap_ctl_t         ctl;
  logic [DATA_W-1:0] sw_data;
  logic [BE_W-1:0]   sw_be;
  logic              accept;

  swap_cfg_regs #(.REG_W(CFG_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .sel_i     (cfg_sel_i),
    .wdata_i   (cfg_wdata_i),
    .rdata_o   (cfg_rdata_o),
    .cpu_cfg_o (cpu_cfg),
    .pci_cmd_o (pci_cmd)
  );

  swap_decide #(.REG_W(CFG_W)) u_decide (
    .src_i      (in_src_i),
    .internal_i (in_internal_i),
    .addr2_i    (in_addr2_i),
    .pci_wide_i (pci_wide_i),
    .cpu_cfg_i  (cpu_cfg),
    .pci_cmd_i  (pci_cmd),
    .ctl_o      (ctl)
  );

  swap_lanes #(.DATA_W(DATA_W)) u_lanes (
    .data_i  (in_data_i),
    .be_i    (in_be_i),
    .bswap_i (ctl.bswap),
    .wswap_i (ctl.wswap),
    .data_o  (sw_data),
    .be_o    (sw_be)
  );

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o   <= 1'b0;
      out_write_o   <= 1'b0;
      out_data_o    <= '0;
      out_be_o      <= '0;
      out_lane_hi_o <= 1'b0;
      out_bswap_o   <= 1'b0;
      out_wswap_o   <= 1'b0;
    end else if (accept) begin
      out_valid_o   <= 1'b1;
      out_write_o   <= in_write_i;
      out_data_o    <= sw_data;
      out_be_o      <= sw_be;
      out_lane_hi_o <= ctl.lane_hi;
      out_bswap_o   <= ctl.bswap;
      out_wswap_o   <= ctl.wswap;
    end else if (out_ready_i) begin
      out_valid_o   <= 1'b0;
    end
  end

  // R10
  accept_to_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o);

  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_be_o));

  // R6
  be_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> $countones(out_be_o) == $countones($past(in_be_i)));

  // R4
  cpu_no_wswap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && (in_src_i == SRC_CPU) |-> !ctl.wswap);

  // R4
  internal_no_wswap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_internal_i |-> !ctl.wswap);

  // R5
  wide_no_wswap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && pci_wide_i |-> !ctl.wswap);

  // R9
  rsvd_no_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && (in_src_i == SRC_RSVD) |-> !ctl.bswap && !ctl.wswap);

endmodule

// File: tb/endian_swap_ctrl_tb.sv
module endian_swap_ctrl_tb_top;

  typedef struct packed {
    logic        wr;
    logic [63:0] data;
    logic [7:0]  be;
    logic        lane;
    logic        bs;
    logic        ws;
    logic [1:0]  src;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        pci_wide = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [1:0]  in_src = '0;
  logic        in_write = 1'b0, in_internal = 1'b0, in_addr2 = 1'b0;
  logic [63:0] in_data = '0;
  logic [7:0]  in_be = '0;
  logic        out_valid, out_ready = 1'b0, out_write, out_lane_hi, out_bswap, out_wswap;
  logic [63:0] out_data;
  logic [7:0]  out_be;

  int checks = 0;
  int failures = 0;
  logic [31:0] cpu_m = '0, pci_m = '0;
  exp_t q[$];

  always #4 clk = ~clk;

  endian_swap_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .pci_wide_i(pci_wide),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_src_i(in_src), .in_write_i(in_write),
    .in_internal_i(in_internal), .in_addr2_i(in_addr2), .in_data_i(in_data), .in_be_i(in_be),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_write_o(out_write),
    .out_data_o(out_data), .out_be_o(out_be), .out_lane_hi_o(out_lane_hi),
    .out_bswap_o(out_bswap), .out_wswap_o(out_wswap)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(logic [1:0] src, logic intl, logic a2, logic wide,
                                 logic wr, logic [63:0] d, logic [7:0] be);
    exp_t e;
    logic le, rb;
    e = '0;
    e.wr = wr; e.src = src;
    le = 1'b1;
    case (src)
      2'd0: begin le = cpu_m[12]; e.bs = !le && intl; end
      2'd1, 2'd2: begin
        rb = (src == 2'd1) ? pci_m[0] : pci_m[16];
        le = rb;
        e.bs = !rb && !intl;
        e.ws = (pci_m[12:10] == 3'b111) && !wide && !intl;
      end
      default: le = 1'b1;
    endcase
    e.lane = a2 ^ !le;
    for (int i = 0; i < 8; i++) begin
      int j, s;
      j = e.ws ? (i ^ 4) : i;
      s = e.bs ? ((j / 4) * 4 + 3 - (j % 4)) : j;
      e.data[i*8 +: 8] = d[s*8 +: 8];
      e.be[i] = be[s];
    end
    return e;
  endfunction

  task automatic cfg_write(input logic sel, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) pci_m = v; else cpu_m = v;
    #1;
    check(cfg_rdata == v, "R1 cfg readback", {32'b0, cfg_rdata}, {32'b0, v});
  endtask

  // one negedge step: drive, then score output and input handshakes
  task automatic step(input bit drive_in, input logic [1:0] src, input logic intl,
                      input logic a2, input logic wr, input logic [63:0] d,
                      input logic [7:0] be, input logic rdy);
    exp_t e;
    @(negedge clk);
    in_valid = drive_in; in_src = src; in_internal = intl; in_addr2 = a2;
    in_write = wr; in_data = d; in_be = be; out_ready = rdy;
    #1;
    check(in_ready == (!out_valid || out_ready), "R10 ready", {63'b0, in_ready}, {63'b0, (!out_valid || out_ready)});
    check(out_valid == (q.size() != 0), "R10 valid latency", {63'b0, out_valid}, {63'b0, q.size() != 0});
    if (out_valid && out_ready && q.size() != 0) begin
      e = q.pop_front();
      check(out_data == e.data, "R6/R7 data", out_data, e.data);
      check(out_be == e.be, "R6/R7 be", {56'b0, out_be}, {56'b0, e.be});
      check(out_lane_hi == e.lane, "R8 lane", {63'b0, out_lane_hi}, {63'b0, e.lane});
      check(out_write == e.wr, "R11 direction", {63'b0, out_write}, {63'b0, e.wr});
      if (e.src == 2'd0)
        check(out_bswap == e.bs, "R2 cpu bswap", {63'b0, out_bswap}, {63'b0, e.bs});
      else if (e.src == 2'd3)
        check(out_bswap == e.bs && out_wswap == e.ws, "R9 reserved", {62'b0, out_bswap, out_wswap}, {62'b0, e.bs, e.ws});
      else
        check(out_bswap == e.bs, "R3 pci bswap", {63'b0, out_bswap}, {63'b0, e.bs});
      if (pci_wide)
        check(out_wswap == e.ws, "R5 wide wswap", {63'b0, out_wswap}, {63'b0, e.ws});
      else
        check(out_wswap == e.ws, "R4 wswap", {63'b0, out_wswap}, {63'b0, e.ws});
    end
    if (in_valid && in_ready) q.push_back(model(src, intl, a2, pci_wide, wr, d, be));
  endtask

  task automatic drain();
    while (q.size() != 0) step(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 64'd0, 8'd0, 1'b1);
    step(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 64'd0, 8'd0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] hold_d;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state, R10 empty output
    check(cfg_rdata == 32'd0, "R1 reset cpu word", {32'b0, cfg_rdata}, 64'd0);
    check(out_valid == 1'b0, "R10 reset valid", {63'b0, out_valid}, 64'd0);
    rst_n = 1'b1;
    cfg_sel = 1'b1; #1;
    check(cfg_rdata == 32'd0, "R1 reset pci word", {32'b0, cfg_rdata}, 64'd0);

    // directed: big-endian CPU, PCI both roles swapping, word exchange on
    cfg_write(1'b0, 32'h0000_0000);
    cfg_write(1'b1, 32'h0000_1C00);
    step(1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 64'h0807_0605_0403_0201, 8'b0000_0011, 1'b1); // R2 internal swap
    step(1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 64'h0807_0605_0403_0201, 8'b0000_0011, 1'b1); // R2 external pass
    step(1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 64'h1122_3344_5566_7788, 8'b0001_0000, 1'b1); // R3/R4/R7 ext
    step(1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 64'h1122_3344_5566_7788, 8'b1000_0000, 1'b1); // R3 internal
    step(1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 64'hA5A5_0000_FFFF_1234, 8'hF0, 1'b1);       // R9
    drain();

    // directed stall: R10 hold
    step(1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 64'hDEAD_BEEF_0123_4567, 8'h0F, 1'b0);
    step(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 64'd0, 8'd0, 1'b0);
    hold_d = out_data;
    step(1'b1, 2'd2, 1'b1, 1'b1, 1'b1, 64'h0, 8'hFF, 1'b0);
    check(out_data == hold_d && !in_ready, "R10 stall hold", out_data, hold_d);
    drain();

    // R5: wide port suppresses word exchange
    pci_wide = 1'b1;
    step(1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 64'h0102_0304_0506_0708, 8'h3C, 1'b1);
    drain();
    pci_wide = 1'b0;

    // random phases
    for (int p = 0; p < 16; p++) begin
      logic [31:0] cw, pw;
      cw = $urandom(); cw[12] = p[0];
      pw = $urandom(); pw[0] = p[1]; pw[16] = p[2];
      if (p[3]) pw[12:10] = 3'b111;
      cfg_write(1'b0, cw);
      cfg_write(1'b1, pw);
      pci_wide = ($urandom() % 4) == 0;
      for (int n = 0; n < 80; n++) begin
        step($urandom() % 4 != 0, 2'($urandom()), 1'($urandom()), 1'($urandom()),
             1'($urandom()), {$urandom(), $urandom()}, 8'($urandom()), $urandom() % 3 != 0);
      end
      drain();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule